// File: doc/BRIEF.md
# Multi-Channel SAR ADC Conversion Sequencer

This controller runs an eight-input successive-approximation converter cell on behalf of the rest of a chip. A single trigger launches a sequence that walks through every channel selected in an enable mask, lowest channel number first. For each channel the sequencer holds the sample-and-hold phase for a programmable number of converter clock periods and then spends ten periods on bit decisions. The converter clock is an enable pulse derived from the master clock by a divide-by-2(N+1) prescaler.

Each result is written to its own channel result register and to a shared most-recent-result register, along with the channel number. A one-cycle transfer request is issued for a DMA engine with a size flag: 16-bit for full-resolution results and 8-bit for reduced ones. In reduced-resolution mode the top eight bits of the cell output are kept right-aligned, and the two upper bits of the field are zero. Channels marked as touch measurements always keep full resolution.

A power-saving mode keeps the analog cell unpowered while idle. In that mode a trigger powers the cell up and waits a programmed start-up time before the first conversion. The cell is switched off again once the last channel has been converted. The analog cell is a small behavioural model that latches a digital stand-in for the channel voltage at the end of sampling.

States: IDLE (waiting for a trigger), WAKE (start-up wait), SAMPLE (sample-and-hold), CONVERT (bit decisions). Transitions: IDLE to WAKE on a trigger with power saving on; IDLE to SAMPLE on a trigger with power saving off; WAKE to SAMPLE when the start-up count expires; SAMPLE to CONVERT when the hold count expires; CONVERT to SAMPLE after the tenth converter clock when another enabled channel remains; CONVERT to IDLE after the tenth converter clock on the last channel.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the sequencer is idle (`busy` low), every result register reads 0, and `eoc`, `ovr` and `xfer_req` are all 0.
- R2: The converter clock has one period every 2*(`cfg_prescale`+1) master clock cycles. No two converter clock pulses fall on consecutive master cycles.
- R3: `busy` stays high for exactly 2*(`cfg_prescale`+1)*T master cycles after the trigger edge. T = (`cfg_sleep` ? `cfg_startup`+1 : 0) + n*(`cfg_shtime`+1+10), where n is the number of enabled channels.
- R4: Enabled channels are converted in ascending channel order. The mask is captured at the trigger. A trigger with an all-zero mask starts nothing.
- R5: A trigger that arrives while `busy` is high is ignored. The running sequence keeps its length and its result count.
- R6: In full resolution the 10-bit cell value is stored unchanged in the channel register and in `last_data`. `last_ch` gives the channel that produced it.
- R7: With `cfg_lowres` high, a non-touch channel stores {2'b00, value[9:2]}. Its transfer request has `xfer_size`=0, and `xfer_data[15:8]` is 0.
- R8: A channel whose bit in `cfg_touch_en` is set is always stored at full 10-bit resolution, whatever `cfg_lowres` is.
- R9: With `cfg_sleep` high, `adc_pwr` is low while idle and high for the whole sequence. With `cfg_sleep` low, `adc_pwr` is always high and no start-up wait is inserted.
- R10: Each conversion sets the `eoc` bit of its channel. If that bit was already set, the `ovr` bit of the channel is set as well. A read (`rd_en` with `rd_ch`) returns the channel result combinationally and clears both bits of that channel.
- R11: Each conversion produces exactly one single-cycle `xfer_req`. `xfer_size`=1 marks a 16-bit transfer carrying the 10-bit result zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Sequence start request |
| cfg_prescale | input | 6 | Converter clock divider setting N, divisor 2(N+1) |
| cfg_shtime | input | 4 | Sample-and-hold length minus one, in converter clocks |
| cfg_startup | input | 8 | Start-up wait minus one, in converter clocks |
| cfg_sleep | input | 1 | Power-saving mode enable |
| cfg_lowres | input | 1 | Reduced 8-bit resolution select |
| cfg_chan_en | input | 8 | Channel enable mask |
| cfg_touch_en | input | 8 | Channels forced to full resolution |
| ana_level | input | 80 | Stand-in analog levels, channel i at bits [10i+9:10i] |
| rd_en | input | 1 | Result read strobe |
| rd_ch | input | 3 | Channel to read |
| rd_data | output | 10 | Result of channel `rd_ch` |
| last_data | output | 10 | Most recent result |
| last_ch | output | 3 | Channel of the most recent result |
| eoc | output | 8 | Per-channel end-of-conversion flags |
| ovr | output | 8 | Per-channel overrun flags |
| xfer_req | output | 1 | Transfer request pulse |
| xfer_size | output | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| xfer_data | output | 16 | Transfer payload |
| busy | output | 1 | Sequence in progress |
| adc_pwr | output | 1 | Analog cell power enable |

## Verification
The hardest case to reach is a trigger that lands in the middle of a long multi-channel sequence. The bench brings it about by pulsing the trigger a few cycles after `busy` rises on random runs, then checks that the measured busy length and the transfer count still match the formula for a single sequence. Overrun is also hard to reach, because the flag needs a second full sequence with no intervening read. A directed case runs two back-to-back sequences and only then reads the channels. Random runs mix touch and reduced-resolution channels in one mask, so both transfer sizes are produced inside a single sequence.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int NCH       = 8;
    localparam int CHW       = 3;
    localparam int RESW      = 10;
    localparam int CONV_CLKS = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_t;

    // Returns {found, index} of the lowest set mask bit at or above 'from'.
    function automatic logic [CHW:0] pick_next(input logic [NCH-1:0] mask,
                                               input logic [CHW:0]   from);
        logic [CHW:0] res;
        res = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) res = {1'b1, CHW'(i)};
        end
        return res;
    endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    localparam int CW = PRE_W + 1;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = {prescale, 1'b1};
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == last) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sar_cell_model.sv
module sar_cell_model
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr,
    input  logic                hold,
    input  logic [CHW-1:0]      chsel,
    input  logic [NCH*RESW-1:0] levels,
    output logic [RESW-1:0]     result
);
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else if (hold && pwr) result <= levels[int'(chsel)*RESW +: RESW];
    end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank
    import sar_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [RESW-1:0] wr_data,
    input  logic            rd_en,
    input  logic [CHW-1:0]  rd_ch,
    output logic [RESW-1:0] rd_data,
    output logic [RESW-1:0] last_data,
    output logic [CHW-1:0]  last_ch,
    output logic [NCH-1:0]  eoc,
    output logic [NCH-1:0]  ovr
);
    logic [RESW-1:0] data_q [NCH];

    assign rd_data = data_q[rd_ch];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            logic hit_wr, hit_rd;
            assign hit_wr = wr && (wr_ch == CHW'(g));
            assign hit_rd = rd_en && (rd_ch == CHW'(g));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[g] <= '0;
                    eoc[g]    <= 1'b0;
                    ovr[g]    <= 1'b0;
                end else if (hit_wr) begin
                    data_q[g] <= wr_data;
                    eoc[g]    <= 1'b1;
                    ovr[g]    <= (eoc[g] && !hit_rd) || (ovr[g] && !hit_rd);
                end else if (hit_rd) begin
                    eoc[g] <= 1'b0;
                    ovr[g] <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
            last_ch   <= '0;
        end else if (wr) begin
            last_data <= wr_data;
            last_ch   <= wr_ch;
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int SH_W  = 4,
    parameter int ST_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [PRE_W-1:0]    cfg_prescale,
    input  logic [SH_W-1:0]     cfg_shtime,
    input  logic [ST_W-1:0]     cfg_startup,
    input  logic                cfg_sleep,
    input  logic                cfg_lowres,
    input  logic [NCH-1:0]      cfg_chan_en,
    input  logic [NCH-1:0]      cfg_touch_en,
    input  logic [NCH*RESW-1:0] ana_level,
    input  logic                rd_en,
    input  logic [CHW-1:0]      rd_ch,
    output logic [RESW-1:0]     rd_data,
    output logic [RESW-1:0]     last_data,
    output logic [CHW-1:0]      last_ch,
    output logic [NCH-1:0]      eoc,
    output logic [NCH-1:0]      ovr,
    output logic                xfer_req,
    output logic                xfer_size,
    output logic [15:0]         xfer_data,
    output logic                busy,
    output logic                adc_pwr
);
    localparam int XW = 16;

    seq_state_t      state;
    logic [ST_W-1:0] phase_cnt;
    logic [CHW-1:0]  cur_ch;
    logic [NCH-1:0]  lat_mask;
    logic            adc_tick;
    logic [CHW:0]    first_pick, next_pick;
    logic            cell_hold, conv_done, eff_low;
    logic [RESW-1:0] cell_res, store_val;

    assign first_pick = pick_next(cfg_chan_en, '0);
    assign next_pick  = pick_next(lat_mask, {1'b0, cur_ch} + 1'b1);

    sar_clk_div #(.PRE_W(PRE_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .prescale(cfg_prescale), .tick(adc_tick)
    );

    // State register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase_cnt <= '0;
            cur_ch    <= '0;
            lat_mask  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    phase_cnt <= '0;
                    if (trig && first_pick[CHW]) begin
                        lat_mask <= cfg_chan_en;
                        cur_ch   <= first_pick[CHW-1:0];
                        state    <= cfg_sleep ? ST_WAKE : ST_SAMPLE;
                    end
                end
                ST_WAKE: if (adc_tick) begin
                    if (phase_cnt == cfg_startup) begin
                        phase_cnt <= '0;
                        state     <= ST_SAMPLE;
                    end else phase_cnt <= phase_cnt + 1'b1;
                end
                ST_SAMPLE: if (adc_tick) begin
                    if (phase_cnt == ST_W'(cfg_shtime)) begin
                        phase_cnt <= '0;
                        state     <= ST_CONVERT;
                    end else phase_cnt <= phase_cnt + 1'b1;
                end
                ST_CONVERT: if (adc_tick) begin
                    if (phase_cnt == ST_W'(CONV_CLKS - 1)) begin
                        phase_cnt <= '0;
                        if (next_pick[CHW]) begin
                            cur_ch <= next_pick[CHW-1:0];
                            state  <= ST_SAMPLE;
                        end else state <= ST_IDLE;
                    end else phase_cnt <= phase_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = (state != ST_IDLE);
        adc_pwr   = cfg_sleep ? (state != ST_IDLE) : 1'b1;
        cell_hold = (state == ST_SAMPLE) && adc_tick && (phase_cnt == ST_W'(cfg_shtime));
        conv_done = (state == ST_CONVERT) && adc_tick && (phase_cnt == ST_W'(CONV_CLKS - 1));
        eff_low   = cfg_lowres && !cfg_touch_en[cur_ch];
        store_val = eff_low ? {2'b00, cell_res[RESW-1:2]} : cell_res;
    end

    sar_cell_model cell_i (
        .clk(clk), .rst_n(rst_n), .pwr(adc_pwr), .hold(cell_hold),
        .chsel(cur_ch), .levels(ana_level), .result(cell_res)
    );

    sar_result_bank bank_i (
        .clk(clk), .rst_n(rst_n), .wr(conv_done), .wr_ch(cur_ch),
        .wr_data(store_val), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
        .last_data(last_data), .last_ch(last_ch), .eoc(eoc), .ovr(ovr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_req  <= 1'b0;
            xfer_size <= 1'b0;
            xfer_data <= '0;
        end else begin
            xfer_req <= conv_done;
            if (conv_done) begin
                xfer_size <= !eff_low;
                xfer_data <= XW'(store_val);
            end
        end
    end
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk
    import sar_seq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input seq_state_t     state,
    input logic           adc_pwr,
    input logic [NCH-1:0] lat_mask,
    input logic [NCH-1:0] eoc,
    input logic           xfer_req,
    input logic           xfer_size,
    input logic [7:0]     xfer_hi
);
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_mask_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(lat_mask));

    assert_pwr_in_convert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT || state == ST_SAMPLE) |-> adc_pwr);

    assert_one_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eoc & ~$past(eoc)));

    assert_lowres_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_size) |-> (xfer_hi == 8'h00));

    assert_xfer_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(adc_tick), .state(state), .adc_pwr(adc_pwr),
    .lat_mask(lat_mask), .eoc(eoc), .xfer_req(xfer_req), .xfer_size(xfer_size),
    .xfer_hi(xfer_data[15:8])
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [5:0]  cfg_prescale = '0;
    logic [3:0]  cfg_shtime = '0;
    logic [7:0]  cfg_startup = '0;
    logic        cfg_sleep = 1'b1;
    logic        cfg_lowres = 1'b0;
    logic [7:0]  cfg_chan_en = '0;
    logic [7:0]  cfg_touch_en = '0;
    logic [79:0] ana_level = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_ch = '0;
    logic [9:0]  rd_data, last_data;
    logic [2:0]  last_ch;
    logic [7:0]  eoc, ovr;
    logic        xfer_req, xfer_size, busy, adc_pwr;
    logic [15:0] xfer_data;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_cnt = 0;
    int pwr_bad  = 0;
    int xf_n     = 0;
    logic [15:0] xf_data [0:15];
    logic        xf_size [0:15];
    logic [2:0]  xf_ch   [0:15];
    logic [9:0]  lvl     [0:7];

    always #2.5 clk = ~clk;

    sar_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_prescale(cfg_prescale),
        .cfg_shtime(cfg_shtime), .cfg_startup(cfg_startup), .cfg_sleep(cfg_sleep),
        .cfg_lowres(cfg_lowres), .cfg_chan_en(cfg_chan_en), .cfg_touch_en(cfg_touch_en),
        .ana_level(ana_level), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
        .last_data(last_data), .last_ch(last_ch), .eoc(eoc), .ovr(ovr),
        .xfer_req(xfer_req), .xfer_size(xfer_size), .xfer_data(xfer_data),
        .busy(busy), .adc_pwr(adc_pwr)
    );

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (busy && !adc_pwr) pwr_bad++;
        if (xfer_req && xf_n < 16) begin
            xf_data[xf_n] = xfer_data;
            xf_size[xf_n] = xfer_size;
            xf_ch[xf_n]   = last_ch;
            xf_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] expv(input logic [9:0] l, input bit low, input bit tch);
        return (low && !tch) ? {2'b00, l[9:2]} : l;
    endfunction

    function automatic int exp_len();
        int t;
        t = cfg_sleep ? int'(cfg_startup) + 1 : 0;
        t += $countones(cfg_chan_en) * (int'(cfg_shtime) + 11);
        return 2 * (int'(cfg_prescale) + 1) * t;
    endfunction

    task automatic set_levels();
        for (int i = 0; i < 8; i++) begin
            lvl[i] = 10'($urandom);
            ana_level[i*10 +: 10] = lvl[i];
        end
    endtask

    task automatic run_seq(input bit extra);
        int cyc = 0;
        busy_cnt = 0; pwr_bad = 0; xf_n = 0;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            trig = (extra && cyc == 4);
        end
        trig = 1'b0;
        if (cyc >= 20000) check(0, "watchdog", cyc, 0);
        @(negedge clk);
    endtask

    // Checks the transfers and flags of the last run (R3, R4, R5, R6, R7, R8, R9, R10, R11)
    task automatic check_run(input logic [7:0] exp_ovr);
        int k = 0;
        int lastc = 0;
        check(busy_cnt == exp_len(), "R3 sequence length (R2 divider)", busy_cnt, exp_len());
        check(xf_n == $countones(cfg_chan_en), "R11 one transfer per conversion (R5)",
              xf_n, $countones(cfg_chan_en));
        if (cfg_sleep) check(pwr_bad == 0, "R9 power held during run", pwr_bad, 0);
        for (int i = 0; i < 8; i++) begin
            if (cfg_chan_en[i] && k < xf_n) begin
                logic [9:0] e;
                e = expv(lvl[i], cfg_lowres, cfg_touch_en[i]);
                check(xf_ch[k] == 3'(i), "R4 ascending order", xf_ch[k], i);
                check(xf_data[k] == {6'b0, e}, cfg_touch_en[i] ? "R8 touch full resolution" :
                      (cfg_lowres ? "R7 reduced result" : "R6 full result"), xf_data[k], e);
                check(xf_size[k] == !(cfg_lowres && !cfg_touch_en[i]), "R11 transfer size",
                      xf_size[k], !(cfg_lowres && !cfg_touch_en[i]));
                k++;
                lastc = i;
            end
        end
        if (cfg_chan_en != 0) begin
            check(last_ch == 3'(lastc), "R6 last channel", last_ch, lastc);
            check(last_data == expv(lvl[lastc], cfg_lowres, cfg_touch_en[lastc]),
                  "R6 last data", last_data, expv(lvl[lastc], cfg_lowres, cfg_touch_en[lastc]));
        end
        check(eoc == cfg_chan_en, "R10 eoc flags", eoc, cfg_chan_en);
        check(ovr == exp_ovr, "R10 overrun flags", ovr, exp_ovr);
        if (cfg_sleep) check(adc_pwr == 1'b0, "R9 power off when idle", adc_pwr, 0);
        else check(adc_pwr == 1'b1, "R9 power stays on", adc_pwr, 1);
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) begin
            if (cfg_chan_en[i]) begin
                @(negedge clk);
                rd_en = 1'b1; rd_ch = 3'(i);
                #1;
                check(rd_data == expv(lvl[i], cfg_lowres, cfg_touch_en[i]), "R6 channel register",
                      rd_data, expv(lvl[i], cfg_lowres, cfg_touch_en[i]));
                @(negedge clk) rd_en = 1'b0;
            end
        end
        @(negedge clk);
        check(eoc == 8'h00, "R10 eoc cleared by read", eoc, 0);
        check(ovr == 8'h00, "R10 ovr cleared by read", ovr, 0);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        check(0, "watchdog expired", 0, 1);
        finish_test();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 idle after reset", busy, 0);
        check(eoc == 8'h00 && ovr == 8'h00, "R1 flags clear", eoc | ovr, 0);
        check(xfer_req == 1'b0, "R1 no transfer", xfer_req, 0);
        check(rd_data == 10'd0 && last_data == 10'd0, "R1 results zero", rd_data, 0);
        check(adc_pwr == 1'b0, "R9 cell off while idle", adc_pwr, 0);

        // Directed: full resolution, sleep with start-up wait
        set_levels();
        cfg_prescale = 6'd0; cfg_shtime = 4'd0; cfg_startup = 8'd3;
        cfg_chan_en = 8'b1010_0101;
        run_seq(0); check_run(8'h00); read_all();

        // Directed: reduced resolution mixed with touch channels, larger divider
        set_levels();
        cfg_prescale = 6'd3; cfg_shtime = 4'd2; cfg_lowres = 1'b1;
        cfg_touch_en = 8'b0000_0100; cfg_chan_en = 8'b0000_1110;
        run_seq(0); check_run(8'h00); read_all();

        // Directed: empty mask starts nothing (R4)
        cfg_chan_en = 8'h00;
        run_seq(0);
        repeat (10) @(negedge clk);
        check(busy_cnt == 0, "R4 empty mask ignored", busy_cnt, 0);

        // Directed: overrun after two unread sequences (R10)
        set_levels();
        cfg_lowres = 1'b0; cfg_touch_en = 8'h00; cfg_chan_en = 8'b1000_0001;
        run_seq(0);
        set_levels();
        run_seq(0); check_run(8'b1000_0001); read_all();

        // Directed: no sleep, cell always on, no start-up wait (R9), late trigger (R5)
        set_levels();
        cfg_sleep = 1'b0; cfg_startup = 8'd50; cfg_chan_en = 8'hFF;
        @(negedge clk);
        check(adc_pwr == 1'b1, "R9 powered while idle without sleep", adc_pwr, 1);
        run_seq(1); check_run(8'h00); read_all();

        // Random runs
        for (int it = 0; it < 24; it++) begin
            set_levels();
            cfg_prescale = 6'($urandom_range(0, 3));
            cfg_shtime   = 4'($urandom_range(0, 4));
            cfg_startup  = 8'($urandom_range(0, 9));
            cfg_sleep    = 1'($urandom);
            cfg_lowres   = 1'($urandom);
            cfg_touch_en = 8'($urandom);
            cfg_chan_en  = 8'($urandom_range(1, 255));
            run_seq(1'($urandom)); check_run(8'h00); read_all();
        end
        finish_test();
    end
endmodule